// File: doc/BRIEF.md
# Fan Speed Tachometer Measurement Unit

This block times the rotation of a fan from its tach pulse line whenever software asks for a reading. Software arms a measurement by writing the trigger bit low and then high. The unit then divides the reference clock into a slower sampling tick, using a prescale of 4, 16, 64 or 256 picked by a 2-bit code. It counts sampling ticks from one synchronized rising tach edge to the next, so the count covers one tach pulse period.

The result word holds a done flag in bit 31 and the 20-bit raw count in bits 19:0. Software turns the count into RPM with ref_clk × 60 ÷ (2 × count × prescale), which assumes a fan that gives two tach pulses per revolution. A 16-bit window value limits how long a reading may take. If no full pulse period is seen within that window, the unit still raises done and reports the all-ones count, so a stalled fan can be told apart from a slow one.

Top module: `tach_meter`

## Requirements
- R1: While reset is held and after it is released, `result_o` reads zero until a measurement completes.
- R2: A measurement starts only on a 0-to-1 change of `trig_i`. On the clock after that change, `result_o` is zero (done and count cleared). Holding `trig_i` high does not start another measurement.
- R3: The sampling tick period equals 4 << (2 × `div_code_i`) reference clocks: 4, 16, 64 or 256 for codes 0 to 3. The tick phase restarts at the trigger.
- R4: The reported count is the number of sampling ticks between two consecutive synchronized rising edges of `tach_i` seen after the trigger, within one tick of tach period ÷ prescale.
- R5: Bit 31 of `result_o` is the done flag, bits 19:0 are the count, and bits 30:20 are always zero.
- R6: If the second tach edge has not arrived once `unit_i` sampling ticks have passed since the trigger (a value of 0 means 65536), done is set with count 0xFFFFF. Done rises exactly on the clock of the last tick in the window.
- R7: The done flag is never set together with a zero count. A pulse period shorter than one tick reports a count of 1.
- R8: Once done is set, `result_o` holds its value until the next trigger rise, whatever the tach line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tach_i | input | 1 | Fan tach pulse, asynchronous |
| trig_i | input | 1 | Measurement trigger bit; a rising change starts a reading |
| div_code_i | input | 2 | Sampling prescale code, prescale = 4 << (2 × code) |
| unit_i | input | 16 | Measurement window in sampling ticks (0 means 65536) |
| result_o | output | 32 | bit 31 done, bits 19:0 raw count, other bits zero |

## Verification
The bench builds the block with its default widths: a 2-bit prescale code, a 16-bit window and a 20-bit count. It drives all four prescale codes against tach periods chosen to give exact tick ratios. Small window values, such as 16 ticks at the fastest prescale, let the stalled-fan timeout and its exact completion cycle be checked within a few dozen clocks. A tach period shorter than the slowest tick brings the zero-count clamp within reach.

// File: rtl/tach_meter_pkg.sv
package tach_meter_pkg;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ARM,
    MS_RUN,
    MS_DONE
  } meas_state_e;

  // Reference clocks per sampling tick for a prescale code.
  function automatic int unsigned tick_divisor(input int unsigned code);
    return 32'd4 << (2 * code);
  endfunction

  // Window length in ticks; a zero setting selects the largest window.
  function automatic int unsigned window_ticks(input int unsigned unit,
                                               input int unsigned unit_w);
    return (unit == 0) ? (32'd1 << unit_w) : unit;
  endfunction

  // A finished measurement never reports zero.
  function automatic int unsigned clamp_nonzero(input int unsigned ticks);
    return (ticks == 0) ? 32'd1 : ticks;
  endfunction

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tach_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  // R4
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tach_tick_gen.sv
module tach_tick_gen #(
  parameter int DIV_CODE_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  restart_i,
  input  logic [DIV_CODE_W-1:0] div_code_i,
  output logic                  tick_o
);
  import tach_meter_pkg::*;

  localparam int unsigned MAX_DIV = 32'd4 << (2 * ((1 << DIV_CODE_W) - 1));
  localparam int PRE_W = $clog2(MAX_DIV);

  logic [PRE_W-1:0] pcnt_q;
  logic             at_end;

  assign at_end = (32'(pcnt_q) >= (tick_divisor(32'(div_code_i)) - 32'd1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (restart_i || at_end) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick_o = at_end & ~restart_i;

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R3
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);

endmodule

// File: rtl/tach_meas_core.sv
module tach_meas_core #(
  parameter int CNT_W  = 20,
  parameter int UNIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_rise_i,
  input  logic              tick_i,
  input  logic              tach_rise_i,
  input  logic [UNIT_W-1:0] unit_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);
  import tach_meter_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_state_e       state_q;
  logic [CNT_W-1:0]  ticks_q;
  logic [UNIT_W:0]   win_q;
  logic              done_q;
  logic [CNT_W-1:0]  count_q;
  logic              win_hit;
  logic              active;

  assign active  = (state_q == MS_ARM) || (state_q == MS_RUN);
  assign win_hit = tick_i &&
                   ((32'(win_q) + 32'd1) >= window_ticks(32'(unit_i), UNIT_W));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      ticks_q <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else if (trig_rise_i) begin
      state_q <= MS_ARM;
      ticks_q <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else if (active) begin
      if (state_q == MS_RUN && tach_rise_i) begin
        done_q  <= 1'b1;
        count_q <= CNT_W'(clamp_nonzero(32'(ticks_q)));
        state_q <= MS_DONE;
      end else if (state_q == MS_ARM && tach_rise_i) begin
        state_q <= MS_RUN;
        ticks_q <= '0;
        if (tick_i) win_q <= win_q + 1'b1;
      end else if (win_hit) begin
        done_q  <= 1'b1;
        count_q <= CNT_MAX;
        state_q <= MS_DONE;
      end else if (tick_i) begin
        win_q <= win_q + 1'b1;
        if (state_q == MS_RUN && ticks_q != CNT_MAX) ticks_q <= ticks_q + 1'b1;
      end
    end
  end

  assign done_o  = done_q;
  assign count_o = count_q;

  // R2
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_rise_i |=> (!done_o && count_o == '0));

  // R7
  nonzero_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o != '0));

  // R8
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trig_rise_i) |=> (done_o && $stable(count_o)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_IDLE) |-> !done_o);

endmodule

// File: rtl/tach_meter.sv
module tach_meter #(
  parameter int DIV_CODE_W = 2,
  parameter int UNIT_W     = 16,
  parameter int CNT_W      = 20,
  parameter int RES_W      = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tach_i,
  input  logic                  trig_i,
  input  logic [DIV_CODE_W-1:0] div_code_i,
  input  logic [UNIT_W-1:0]     unit_i,
  output logic [RES_W-1:0]      result_o
);
  localparam int PAD_W = RES_W - 1 - CNT_W;

  logic             trig_q;
  logic             trig_rise;
  logic             tick;
  logic             tach_rise;
  logic             done;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign trig_rise = trig_i & ~trig_q;

  tach_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .rise_o (tach_rise)
  );

  tach_tick_gen #(.DIV_CODE_W(DIV_CODE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (trig_rise),
    .div_code_i (div_code_i),
    .tick_o     (tick)
  );

  tach_meas_core #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_rise_i (trig_rise),
    .tick_i      (tick),
    .tach_rise_i (tach_rise),
    .unit_i      (unit_i),
    .done_o      (done),
    .count_o     (count)
  );

  assign result_o = {done, {PAD_W{1'b0}}, count};

  // R2
  held_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && trig_i) |-> !trig_rise);

endmodule

// File: tb/tach_meter_tb.sv
module tach_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 5;
  localparam int V_DIV [VEC_N] = '{0, 1, 2, 3, 0};
  localparam int V_PER [VEC_N] = '{400, 800, 1280, 2560, 40};
  localparam int V_EXP [VEC_N] = '{100, 50, 20, 10, 10};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach = 1'b0;
  logic        trig = 1'b0;
  logic [1:0]  div_code = 2'd0;
  logic [15:0] unit = 16'h1000;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  int tach_per = 0;
  int tach_cnt = 0;
  bit ended = 1'b0;
  logic [31:0] held;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tach_meter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tach_i(tach), .trig_i(trig),
    .div_code_i(div_code), .unit_i(unit), .result_o(result)
  );

  always @(negedge clk) begin
    if (tach_per == 0) begin
      tach = 1'b0; tach_cnt = 0;
    end else if (tach_cnt >= tach_per / 2 - 1) begin
      tach = ~tach; tach_cnt = 0;
    end else begin
      tach_cnt = tach_cnt + 1;
    end
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic fire_trigger();
    @(negedge clk); trig = 1'b0;
    @(negedge clk); trig = 1'b1;
  endtask

  task automatic measure(input int dc, input int un, input int per);
    @(negedge clk);
    div_code = 2'(dc); unit = 16'(un); tach_per = per;
    repeat (4) @(negedge clk);
    fire_trigger();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (result[31]) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1 during reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1 after reset", result, 32'h0);

    // R3 R4: vector table over all prescale codes
    for (int v = 0; v < VEC_N; v++) begin
      measure(V_DIV[v], 16'h1000, V_PER[v]);
      check_eq("R4 done flag", {31'd0, result[31]}, 32'd1);
      check_rng("R3 R4 count", int'(result[19:0]), V_EXP[v] - 1, V_EXP[v] + 1);
    end
    // R5 unused field
    check_eq("R5 bits 30:20", {21'd0, result[30:20]}, 32'd0);

    // R8 trigger held high: no new measurement, value held
    held = result;
    repeat (500) @(negedge clk);
    check_eq("R8 hold while trigger high", result, held);

    // R2 retrigger clears result on the next clock
    @(negedge clk); trig = 1'b0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    check_eq("R2 cleared after trigger", result, 32'h0);

    // R6 stalled fan, 16-tick window at prescale 4 ends at clock 64
    @(negedge clk);
    tach_per = 0; div_code = 2'd0; unit = 16'd16;
    repeat (4) @(negedge clk);
    fire_trigger();
    repeat (60) @(negedge clk);
    check_eq("R6 not done before window", {31'd0, result[31]}, 32'd0);
    repeat (10) @(negedge clk);
    check_eq("R6 stall timeout", result, 32'h800F_FFFF);

    // R6 slow fan exceeds a short window
    measure(0, 4, 400);
    check_eq("R6 slow fan timeout", result, 32'h800F_FFFF);

    // R7 pulses faster than one tick clamp to one
    measure(3, 16'h1000, 20);
    check_eq("R7 zero clamp", result, 32'h8000_0001);

    finish_run();
  end
endmodule